// File: doc/BRIEF.md
# CAN Receive Identifier Filter and Frame Queue

This block sits behind a CAN frame decoder. Each decoded frame carries an identifier, its type bits (standard/extended and data/remote), a length code and up to eight data bytes. The block compares the identifier against a table of filter elements, each with its own mask, and stores accepted frames in a six-entry queue. The host reads the frame at the head of the queue, pops it when done, and watches a sticky overflow flag.

The table is eight 32-bit identifier words and eight 32-bit mask words, written through a simple write port. A format input selects how the words are read: eight extended elements, sixteen standard elements (two per word) or thirty-two 8-bit partial elements (four per word). A two-state controller handles each frame: `ST_IDLE` captures a frame when `in_valid` is high and moves to `ST_EVAL`; `ST_EVAL` evaluates the filters, pushes or drops the frame, and always returns to `ST_IDLE`.

Top module: `can_rxf`

## Requirements
- R1: After reset the queue is empty (`out_avail`=0), `out_ovf`=0 and every table word is zero, so in extended format element 0 accepts any standard data frame with hit index 0.
- R2: The queue holds up to 6 frames and presents them in arrival order; a `pop` cycle removes the head, and a `pop` while empty changes nothing.
- R3: Extended format (`cfg_fmt`=0): element e is word e, with ID in bits 28:0, IDE in bit 30 and RTR in bit 31; the mask word bits 28:0 select compared ID bits (1 = must match, 0 = ignored), and IDE and RTR must always equal the frame's.
- R4: Standard format (`cfg_fmt`=1): element e is half e%2 of word e/2 (half 0 = bits 15:0); in a half, bits 10:0 are the ID, bit 14 IDE and bit 15 RTR; the masked compare is against frame ID bits 10:0 for a standard frame and 28:18 for an extended one, and IDE and RTR must match.
- R5: Partial format (`cfg_fmt`=2): element e is byte e%4 of word e/4 (byte 0 = bits 7:0), masked against the top 8 ID bits (10:3 standard, 28:21 extended); IDE and RTR are not checked.
- R6: With `cfg_fmt`=3 no frame is accepted.
- R7: A frame is accepted if any element matches, and `out_hit` carries the lowest-numbered matching element.
- R8: A frame presented with `in_valid` at clock edge k is visible on the outputs after edge k+1; a frame presented at edge k+1 is ignored, so frames must be at least two cycles apart.
- R9: An accepted frame arriving with 6 frames stored is dropped, the queue is unchanged, and `out_ovf` rises and stays set until an `ovf_clr` cycle; a drop in the same cycle as `ovf_clr` leaves it set.
- R10: A frame that matches no element is not stored.
- R11: The stored frame keeps its ID, IDE, RTR, length code and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Table format: 0 extended, 1 standard, 2 partial, 3 off |
| tbl_wr | input | 1 | Table word write strobe |
| tbl_mask | input | 1 | 1 writes the mask word, 0 the identifier word |
| tbl_addr | input | 3 | Table word index |
| tbl_wdata | input | 32 | Table word value |
| in_valid | input | 1 | Decoded frame present |
| in_ide | input | 1 | Frame is extended |
| in_rtr | input | 1 | Frame is remote |
| in_id | input | 29 | Identifier (standard in bits 10:0) |
| in_dlc | input | 4 | Length code |
| in_data | input | 64 | Data bytes |
| pop | input | 1 | Remove head frame |
| ovf_clr | input | 1 | Clear overflow flag |
| out_avail | output | 1 | Queue not empty |
| out_ide | output | 1 | Head frame IDE |
| out_rtr | output | 1 | Head frame RTR |
| out_id | output | 29 | Head frame identifier |
| out_dlc | output | 4 | Head frame length code |
| out_data | output | 64 | Head frame data |
| out_hit | output | 5 | Lowest matching element of head frame |
| out_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default eight table words and six queue entries, small enough that every element of every format is targeted in a sweep: each format runs 96 frames derived from the table words, some with a single flipped ID bit that lands either in a compared or an ignored mask position, and some with a flipped RTR. Expected acceptance and hit index come from an arithmetic model of the element layouts. The six-entry depth puts the full-queue drop, the sticky flag and its clearing within a few dozen cycles, along with the back-to-back frame that must be ignored.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
    localparam int ID_W   = 29;
    localparam int DATA_W = 64;

    typedef enum logic [1:0] {
        FMT_EXT  = 2'd0,
        FMT_STD  = 2'd1,
        FMT_PART = 2'd2,
        FMT_OFF  = 2'd3
    } fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } st_e;

    typedef struct packed {
        logic              rtr;
        logic              ide;
        logic [ID_W-1:0]   id;
        logic [3:0]        dlc;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/can_rxf_table.sv
module can_rxf_table #(
    parameter int NWORD = 8,
    parameter int AW    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic                   sel_mask,
    input  logic [AW-1:0]          addr,
    input  logic [31:0]            wdata,
    output logic [NWORD-1:0][31:0] id_tbl,
    output logic [NWORD-1:0][31:0] mask_tbl
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_tbl   <= '0;
            mask_tbl <= '0;
        end else if (wr) begin
            if (sel_mask) mask_tbl[addr] <= wdata;
            else          id_tbl[addr]   <= wdata;
        end
    end
endmodule

// File: rtl/can_rxf_match.sv
module can_rxf_match
    import can_rxf_pkg::*;
#(
    parameter int NWORD = 8,
    parameter int HW    = 5
) (
    input  fmt_e                   fmt,
    input  logic [NWORD-1:0][31:0] id_tbl,
    input  logic [NWORD-1:0][31:0] mask_tbl,
    input  logic                   f_ide,
    input  logic                   f_rtr,
    input  logic [ID_W-1:0]        f_id,
    output logic                   hit,
    output logic [HW-1:0]          idx
);
    localparam int NEXT = NWORD;
    localparam int NSTD = 2 * NWORD;
    localparam int NPRT = 4 * NWORD;

    logic [10:0]     key11;
    logic [7:0]      key8;
    logic [NEXT-1:0] hx;
    logic [NSTD-1:0] hs;
    logic [NPRT-1:0] hp;
    logic [NPRT-1:0] vec;

    assign key11 = f_ide ? f_id[28:18] : f_id[10:0];
    assign key8  = f_ide ? f_id[28:21] : f_id[10:3];

    for (genvar e = 0; e < NEXT; e++) begin : g_ext
        assign hx[e] = (id_tbl[e][31] == f_rtr) && (id_tbl[e][30] == f_ide) &&
                       (((f_id ^ id_tbl[e][28:0]) & mask_tbl[e][28:0]) == '0);
    end

    for (genvar e = 0; e < NSTD; e++) begin : g_std
        localparam int W = e / 2;
        localparam int L = (e % 2) * 16;
        assign hs[e] = (id_tbl[W][L+15] == f_rtr) && (id_tbl[W][L+14] == f_ide) &&
                       (((key11 ^ id_tbl[W][L +: 11]) & mask_tbl[W][L +: 11]) == '0);
    end

    for (genvar e = 0; e < NPRT; e++) begin : g_prt
        localparam int W = e / 4;
        localparam int L = (e % 4) * 8;
        assign hp[e] = (((key8 ^ id_tbl[W][L +: 8]) & mask_tbl[W][L +: 8]) == '0);
    end

    always_comb begin
        vec = '0;
        unique case (fmt)
            FMT_EXT:  vec[NEXT-1:0] = hx;
            FMT_STD:  vec[NSTD-1:0] = hs;
            FMT_PART: vec           = hp;
            FMT_OFF:  vec           = '0;
        endcase
        hit = |vec;
        idx = '0;
        for (int i = NPRT - 1; i >= 0; i--) begin
            if (vec[i]) idx = HW'(i);
        end
    end
endmodule

// File: rtl/can_rxf_queue.sv
module can_rxf_queue
    import can_rxf_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int HW    = 5,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  frame_t        push_frm,
    input  logic [HW-1:0] push_idx,
    input  logic          pop,
    output logic          avail,
    output logic          full,
    output frame_t        head_frm,
    output logic [HW-1:0] head_idx,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    frame_t        mem_frm [DEPTH];
    logic [HW-1:0] mem_idx [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign avail    = (count != '0);
    assign full     = (count == CW'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && avail;
    assign head_frm = mem_frm[rp];
    assign head_idx = mem_idx[rp];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_frm[i] <= '0;
                mem_idx[i] <= '0;
            end
        end else begin
            if (do_push) begin
                mem_frm[wp] <= push_frm;
                mem_idx[wp] <= push_idx;
                wp          <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end
endmodule

// File: rtl/can_rxf.sv
module can_rxf
    import can_rxf_pkg::*;
#(
    parameter int NWORD = 8,
    parameter int DEPTH = 6,
    localparam int AW   = $clog2(NWORD),
    localparam int HW   = $clog2(4 * NWORD),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_fmt,
    input  logic              tbl_wr,
    input  logic              tbl_mask,
    input  logic [AW-1:0]     tbl_addr,
    input  logic [31:0]       tbl_wdata,
    input  logic              in_valid,
    input  logic              in_ide,
    input  logic              in_rtr,
    input  logic [ID_W-1:0]   in_id,
    input  logic [3:0]        in_dlc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              pop,
    input  logic              ovf_clr,
    output logic              out_avail,
    output logic              out_ide,
    output logic              out_rtr,
    output logic [ID_W-1:0]   out_id,
    output logic [3:0]        out_dlc,
    output logic [DATA_W-1:0] out_data,
    output logic [HW-1:0]     out_hit,
    output logic              out_ovf
);
    logic [NWORD-1:0][31:0] id_tbl, mask_tbl;
    st_e           st_q, st_d;
    frame_t        cap_q, q_head;
    logic          m_hit, q_full, q_push, f_drop;
    logic [HW-1:0] m_idx;
    logic [CW-1:0] q_cnt;

    can_rxf_table #(.NWORD(NWORD), .AW(AW)) u_table (
        .clk(clk), .rst_n(rst_n), .wr(tbl_wr), .sel_mask(tbl_mask),
        .addr(tbl_addr), .wdata(tbl_wdata), .id_tbl(id_tbl), .mask_tbl(mask_tbl)
    );

    can_rxf_match #(.NWORD(NWORD), .HW(HW)) u_match (
        .fmt(fmt_e'(cfg_fmt)), .id_tbl(id_tbl), .mask_tbl(mask_tbl),
        .f_ide(cap_q.ide), .f_rtr(cap_q.rtr), .f_id(cap_q.id),
        .hit(m_hit), .idx(m_idx)
    );

    can_rxf_queue #(.DEPTH(DEPTH), .HW(HW), .CW(CW)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_frm(cap_q), .push_idx(m_idx),
        .pop(pop), .avail(out_avail), .full(q_full), .head_frm(q_head),
        .head_idx(out_hit), .count(q_cnt)
    );

    // state register and frame capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cap_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && in_valid)
                cap_q <= '{rtr: in_rtr, ide: in_ide, id: in_id, dlc: in_dlc, data: in_data};
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (in_valid) st_d = ST_EVAL;
            ST_EVAL: st_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        q_push = 1'b0;
        f_drop = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_EVAL: begin
                q_push = m_hit && !q_full;
                f_drop = m_hit && q_full;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       out_ovf <= 1'b0;
        else if (f_drop)  out_ovf <= 1'b1;
        else if (ovf_clr) out_ovf <= 1'b0;
    end

    assign out_ide  = q_head.ide;
    assign out_rtr  = q_head.rtr;
    assign out_id   = q_head.id;
    assign out_dlc  = q_head.dlc;
    assign out_data = q_head.data;
endmodule

// File: rtl/can_rxf_chk.sv
module can_rxf_chk
    import can_rxf_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pop,
    input logic          ovf_clr,
    input logic          out_avail,
    input logic          out_ovf,
    input frame_t        head,
    input st_e           st,
    input logic          hit,
    input logic [CW-1:0] cnt
);
    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R2
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_avail && !pop |=> $stable(head)); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf && !ovf_clr |=> out_ovf); // R9
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EVAL) && hit && (cnt == CW'(DEPTH)) |=> out_ovf); // R9
    AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EVAL) && !hit && !pop |=> $stable(cnt)); // R10
    AST_ACCEPT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EVAL) && hit && (cnt < CW'(DEPTH)) |=> out_avail); // R8
endmodule

bind can_rxf can_rxf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pop(pop), .ovf_clr(ovf_clr),
    .out_avail(out_avail), .out_ovf(out_ovf), .head(q_head),
    .st(st_q), .hit(m_hit), .cnt(q_cnt)
);

// File: tb/can_rxf_bench.sv
module can_rxf_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        tbl_wr = 1'b0, tbl_mask = 1'b0;
    logic [2:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        in_valid = 1'b0, in_ide = 1'b0, in_rtr = 1'b0;
    logic [28:0] in_id = '0;
    logic [3:0]  in_dlc = '0;
    logic [63:0] in_data = '0;
    logic        pop = 1'b0, ovf_clr = 1'b0;
    logic        out_avail, out_ide, out_rtr, out_ovf;
    logic [28:0] out_id;
    logic [3:0]  out_dlc;
    logic [63:0] out_data;
    logic [4:0]  out_hit;

    int nvec = 0, nerr = 0;
    bit done = 0;
    logic [31:0] tid [8];
    logic [31:0] tmk [8];

    always #10 clk = ~clk;

    can_rxf u_can_rxf (.*);

    task automatic check(input bit ok, input string msg);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic wr_tbl(input bit m, input int a, input logic [31:0] d);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_mask = m; tbl_addr = 3'(a); tbl_wdata = d;
        @(negedge clk);
        tbl_wr = 1'b0;
        if (m) tmk[a] = d; else tid[a] = d;
    endtask

    task automatic send(input bit ide, input bit rtr, input logic [28:0] id,
                        input logic [3:0] dlc, input logic [63:0] data);
        @(negedge clk);
        in_valid = 1'b1; in_ide = ide; in_rtr = rtr; in_id = id; in_dlc = dlc; in_data = data;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_pop();
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    // arithmetic model of the element layouts
    task automatic model(input int f, input bit ide, input bit rtr, input logic [28:0] id,
                         output bit hit, output int idx);
        logic [10:0] k11;
        logic [7:0]  k8;
        k11 = ide ? id[28:18] : id[10:0];
        k8  = ide ? id[28:21] : id[10:3];
        hit = 0; idx = 0;
        for (int e = 31; e >= 0; e--) begin
            bit m = 0;
            if (f == 0 && e < 8)
                m = tid[e][31] == rtr && tid[e][30] == ide &&
                    ((id ^ tid[e][28:0]) & tmk[e][28:0]) == 0;
            else if (f == 1 && e < 16)
                m = tid[e/2][(e%2)*16+15] == rtr && tid[e/2][(e%2)*16+14] == ide &&
                    ((k11 ^ tid[e/2][(e%2)*16 +: 11]) & tmk[e/2][(e%2)*16 +: 11]) == 0;
            else if (f == 2)
                m = ((k8 ^ tid[e/4][(e%4)*8 +: 8]) & tmk[e/4][(e%4)*8 +: 8]) == 0;
            if (m) begin hit = 1; idx = e; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++; nvec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin tid[i] = '0; tmk[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_avail == 0 && out_ovf == 0,
              $sformatf("R1 reset avail=%0d ovf=%0d exp 0 0", out_avail, out_ovf));
        send(0, 0, 29'd5, 4'd2, 64'hAB);
        check(out_avail && out_hit == 0 && out_id == 29'd5,
              $sformatf("R1 zero table avail=%0d hit=%0d id=%0h exp 1 0 5", out_avail, out_hit, out_id));
        do_pop();

        // format sweeps R3 R4 R5 R6 R7 R10 R11
        for (int f = 0; f < 4; f++) begin
            cfg_fmt = 2'(f);
            for (int w = 0; w < 8; w++) begin
                wr_tbl(0, w, (32'h9E3779B9 * (w + 3)) ^ (32'h12345678 * f));
                wr_tbl(1, w, 32'hFFFFFFFF ^ (32'h01010101 << w));
            end
            for (int n = 0; n < 96; n++) begin
                int nel, e, idx;
                bit ide, rtr, hit;
                logic [28:0] id;
                logic [15:0] h;
                logic [7:0]  b;
                logic [63:0] d;
                string tag;
                nel = (f == 1) ? 16 : (f == 2) ? 32 : 8;
                e = n % nel;
                if (f == 1) begin
                    h = tid[e/2][(e%2)*16 +: 16];
                    ide = h[14]; rtr = h[15];
                    id = ide ? {h[10:0], 18'(n * 13)} : {18'd0, h[10:0]};
                end else if (f == 2) begin
                    b = tid[e/4][(e%4)*8 +: 8];
                    ide = n[0]; rtr = n[1];
                    id = ide ? {b, 21'(n * 977)} : {18'd0, b, 3'(n)};
                end else begin
                    id = tid[e][28:0]; ide = tid[e][30]; rtr = tid[e][31];
                end
                if (n % 3 == 1) id = id ^ (29'd1 << ((n * 7) % 29));
                if (n % 5 == 2) rtr = ~rtr;
                d = {32'(n), ~32'(n * f)};
                model(f, ide, rtr, id, hit, idx);
                send(ide, rtr, id, 4'(n % 9), d);
                tag = !hit ? ((f == 3) ? "R6" : "R10") :
                      (f == 0) ? "R3/R7/R11" : (f == 1) ? "R4/R7/R11" : "R5/R7/R11";
                check(out_avail == hit &&
                      (!hit || (out_id == id && out_ide == ide && out_rtr == rtr &&
                                out_dlc == 4'(n % 9) && out_data == d && out_hit == 5'(idx))),
                      $sformatf("%s fmt=%0d n=%0d avail=%0d hit=%0d id=%0h exp avail=%0d hit=%0d id=%0h",
                                tag, f, n, out_avail, out_hit, out_id, hit, idx, id));
                if (out_avail) do_pop();
            end
        end

        // accept-all for queue tests: word0 standard data, mask 0
        cfg_fmt = 2'd0;
        wr_tbl(0, 0, 32'd0);
        wr_tbl(1, 0, 32'd0);

        // R8: back-to-back frame ignored
        @(negedge clk);
        in_valid = 1'b1; in_ide = 0; in_rtr = 0; in_id = 29'd1; in_data = 64'd111;
        @(negedge clk);
        in_id = 29'd2; in_data = 64'd222;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_avail && out_data == 64'd111,
              $sformatf("R8 first frame data=%0d exp 111", out_data));
        do_pop();
        @(negedge clk);
        check(!out_avail, $sformatf("R8 second frame stored avail=%0d exp 0", out_avail));

        // R9 / R2: fill, overflow, order
        for (int i = 0; i < 7; i++) begin
            send(0, 0, 29'(i), 4'd1, 64'(100 + i));
            check(out_ovf == (i == 6), $sformatf("R9 ovf after %0d frames=%0d exp %0d", i + 1, out_ovf, i == 6));
        end
        for (int i = 0; i < 6; i++) begin
            check(out_avail && out_data == 64'(100 + i),
                  $sformatf("R2 order slot %0d data=%0d exp %0d", i, out_data, 100 + i));
            do_pop();
        end
        @(negedge clk);
        check(!out_avail, $sformatf("R2 empty after six pops avail=%0d exp 0", out_avail));
        check(out_ovf, $sformatf("R9 sticky ovf=%0d exp 1", out_ovf));
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check(!out_ovf, $sformatf("R9 cleared ovf=%0d exp 0", out_ovf));

        // R2: pop while empty is ignored
        do_pop();
        send(0, 0, 29'd9, 4'd3, 64'd555);
        check(out_avail && out_data == 64'd555,
              $sformatf("R2 after empty pop data=%0d exp 555", out_data));
        do_pop();
        @(negedge clk);
        check(!out_avail, $sformatf("R2 single entry removed avail=%0d exp 0", out_avail));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule